// File: doc/BRIEF.md
# Two-Step Single-Slope Conversion Sequencer

This block holds the digital side of a column-parallel two-step single-slope converter. One shared controller runs every column at once, and each column has its own small slice of logic. A conversion has two parts. In the coarse part, a reference-select count steps down through every reference while the ramp code is held at full scale. The first comparator trip in a column stores that column's coarse code. In the fine part, each column keeps the reference named by its coarse code and the shared ramp code counts upward. The first trip in this part stores the fine code. A conversion takes K + 2^FB cycles, where K = 2^P is the number of references. A plain single-slope converter with the same resolution needs 2^n cycles.

The comparators, the reference ladder and the ramp DAC sit outside the block. The block drives the per-column one-hot reference-switch enables, the ramp code and a coarse-phase flag. It takes back one comparator bit per column, sampled once per clock. Results are plain status pins rather than a stream. They stay stable from the done pulse until the next accepted start, so there is no back-pressure to manage. The fine ramp starts one section below the top reference, which makes adjacent sections overlap. The extra fine bit carries this redundancy: fine code f stands for ramp level (K-2)*2^(FB-1) + f.

Top module: `ts_ss_sequencer`

## Requirements
- R1: After reset, done, the phase flag, every reference enable, every stored code and every saturation flag are 0, and the ramp code is 0.
- R2: A start pulse while idle begins a coarse phase of exactly K cycles. In that phase the phase flag is high, the ramp code is all ones, and each column closes exactly one switch, with index K-1 in the first cycle and one lower in each following cycle.
- R3: In the coarse phase, the first cycle in which a column's comparator bit is high stores the current switch index as that column's coarse code. Later high cycles in the same phase leave the code unchanged.
- R4: The fine phase follows at once and lasts 2^FB cycles. The phase flag is low, the ramp code counts 0, 1, ... 2^FB-1, and each column closes only the switch whose index equals its stored coarse code.
- R5: In the fine phase, the first cycle in which a column's comparator bit is high stores the ramp code of that cycle as the column's fine code. Later trips are ignored.
- R6: A column whose comparator stays low for the whole coarse phase stores coarse code 0 and raises its coarse saturation flag. Its fine phase then uses reference 0.
- R7: A column whose comparator stays low for the whole fine phase stores fine code 2^FB-1 (all ones) and raises its fine saturation flag.
- R8: done is high for exactly one cycle. It rises on the (K + 2^FB)-th clock edge after the edge that samples start, and the block is idle again in that same cycle.
- R9: A start pulse while a conversion is running has no effect. The conversion ends on schedule and no second conversion follows it.
- R10: Columns are independent. One column's comparator bit never changes another column's codes or flags.
- R11: For a comparator that trips once its reference-adjusted ramp level reaches the input, a column that does not saturate gives fine code + (K-2-coarse code)*2^(FB-1) equal to the input level in LSB.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a conversion (acted on only when idle) |
| comp | input | N_COLS | Comparator bit per column, synchronous |
| phase_coarse | output | 1 | High during the coarse phase |
| ramp_code | output | FB | Ramp DAC code |
| ref_en | output | N_COLS*K | One-hot reference-switch enables, K per column |
| coarse_code | output | N_COLS*P | Stored coarse code per column |
| fine_code | output | N_COLS*FB | Stored fine code per column |
| sat_coarse | output | N_COLS | Coarse phase ended with no trip |
| sat_fine | output | N_COLS | Fine phase ended with no trip |
| done | output | 1 | One-cycle end-of-conversion strobe |

## Verification
The bench models each comparator from the block's own switch enables and ramp code, so every stored code also shows that the right reference was selected. Input levels are chosen at the edges of coarse sections (0, 511, 512, 3071, 3072, 4095) and in their interiors. These values tell an off-by-one coarse index apart from a fine code that is one step off, and they catch a wrong overlap offset. Comparators held low in one phase only, and only on one column, separate the saturation paths from ordinary trips and show that columns do not affect each other. A start pulse issued partway through a conversion shows that the cycle count and the return to idle stay as specified.

// File: rtl/ts_pkg.sv
package ts_pkg;
  typedef enum logic [1:0] {
    PH_IDLE   = 2'd0,
    PH_COARSE = 2'd1,
    PH_FINE   = 2'd2
  } phase_t;
endpackage

// File: rtl/ts_seq_ctrl.sv
module ts_seq_ctrl
  import ts_pkg::*;
#(
  parameter int P  = 3,
  parameter int FB = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  output phase_t        phase,
  output logic [P-1:0]  coarse_cnt,
  output logic [FB-1:0] fine_cnt,
  output logic [FB-1:0] ramp_code,
  output logic          clr,
  output logic          last_coarse,
  output logic          last_fine,
  output logic          done
);
  // shared sequencer: one count broadcast to every column
  assign clr         = start && (phase == PH_IDLE);
  assign last_coarse = (phase == PH_COARSE) && (coarse_cnt == '0);
  assign last_fine   = (phase == PH_FINE) && (&fine_cnt);

  always_comb begin
    ramp_code = '0;
    if (phase == PH_COARSE) ramp_code = '1;
    else if (phase == PH_FINE) ramp_code = fine_cnt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase      <= PH_IDLE;
      coarse_cnt <= '0;
      fine_cnt   <= '0;
      done       <= 1'b0;
    end else begin
      done <= 1'b0;
      case (phase)
        PH_IDLE: begin
          if (start) begin
            phase      <= PH_COARSE;
            coarse_cnt <= '1;
          end
        end
        PH_COARSE: begin
          if (coarse_cnt == '0) begin
            phase    <= PH_FINE;
            fine_cnt <= '0;
          end else begin
            coarse_cnt <= coarse_cnt - 1'b1;
          end
        end
        PH_FINE: begin
          if (&fine_cnt) begin
            phase <= PH_IDLE;
            done  <= 1'b1;
          end else begin
            fine_cnt <= fine_cnt + 1'b1;
          end
        end
        default: phase <= PH_IDLE;
      endcase
    end
  end

  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R8
  AST_COARSE_DOWNSTEP: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_COARSE && coarse_cnt != '0) |=>
      (phase == PH_COARSE && coarse_cnt == $past(coarse_cnt) - P'(1))); // R2
  AST_FINE_UPSTEP: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_FINE && !(&fine_cnt)) |=>
      (phase == PH_FINE && fine_cnt == $past(fine_cnt) + FB'(1))); // R4
  AST_BUSY_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_FINE && start && !(&fine_cnt)) |=> (phase == PH_FINE)); // R9
endmodule

// File: rtl/ts_column.sv
module ts_column
  import ts_pkg::*;
#(
  parameter int P  = 3,
  parameter int FB = 10,
  localparam int K = 1 << P
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  phase_t        phase,
  input  logic [P-1:0]  coarse_cnt,
  input  logic [FB-1:0] fine_cnt,
  input  logic          last_coarse,
  input  logic          last_fine,
  input  logic          comp,
  output logic [K-1:0]  ref_en,
  output logic [P-1:0]  c_code,
  output logic [FB-1:0] f_code,
  output logic          sat_c,
  output logic          sat_f
);
  logic         c_hit, f_hit;
  logic [P-1:0] sel;

  // select mux ahead of the switch decoder
  assign sel = (phase == PH_COARSE) ? coarse_cnt : c_code;

  for (genvar g = 0; g < K; g++) begin : g_dec
    assign ref_en[g] = (phase != PH_IDLE) && (sel == P'(g));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      c_code <= '0; f_code <= '0;
      c_hit  <= 1'b0; f_hit <= 1'b0;
      sat_c  <= 1'b0; sat_f <= 1'b0;
    end else if (clr) begin
      c_code <= '0; f_code <= '0;
      c_hit  <= 1'b0; f_hit <= 1'b0;
      sat_c  <= 1'b0; sat_f <= 1'b0;
    end else if (phase == PH_COARSE && !c_hit) begin
      if (comp) begin
        c_code <= coarse_cnt;
        c_hit  <= 1'b1;
      end else if (last_coarse) begin
        c_code <= coarse_cnt;
        sat_c  <= 1'b1;
      end
    end else if (phase == PH_FINE && !f_hit) begin
      if (comp) begin
        f_code <= fine_cnt;
        f_hit  <= 1'b1;
      end else if (last_fine) begin
        f_code <= fine_cnt;
        sat_f  <= 1'b1;
      end
    end
  end

  AST_ONE_SWITCH: assert property (@(posedge clk) disable iff (!rst_n)
    (phase != PH_IDLE) |-> $onehot(ref_en)); // R2
  AST_IDLE_OPEN: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_IDLE) |-> (ref_en == '0)); // R1
  AST_COARSE_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_COARSE && c_hit) |=> $stable(c_code)); // R3
  AST_FINE_REF_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_FINE && !last_fine) |=> $stable(c_code)); // R4
  AST_FINE_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_FINE && f_hit) |=> $stable(f_code)); // R5
  AST_SAT_COARSE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    sat_c |-> (c_code == '0)); // R6
  AST_SAT_FINE_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    sat_f |-> (&f_code)); // R7
endmodule

// File: rtl/ts_ss_sequencer.sv
module ts_ss_sequencer
  import ts_pkg::*;
#(
  parameter int P      = 3,
  parameter int FB     = 10,
  parameter int N_COLS = 4,
  localparam int K     = 1 << P
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start,
  input  logic [N_COLS-1:0]    comp,
  output logic                 phase_coarse,
  output logic [FB-1:0]        ramp_code,
  output logic [N_COLS*K-1:0]  ref_en,
  output logic [N_COLS*P-1:0]  coarse_code,
  output logic [N_COLS*FB-1:0] fine_code,
  output logic [N_COLS-1:0]    sat_coarse,
  output logic [N_COLS-1:0]    sat_fine,
  output logic                 done
);
  phase_t        phase;
  logic [P-1:0]  coarse_cnt;
  logic [FB-1:0] fine_cnt;
  logic          clr, last_coarse, last_fine;

  ts_seq_ctrl #(.P(P), .FB(FB)) u_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .start       (start),
    .phase       (phase),
    .coarse_cnt  (coarse_cnt),
    .fine_cnt    (fine_cnt),
    .ramp_code   (ramp_code),
    .clr         (clr),
    .last_coarse (last_coarse),
    .last_fine   (last_fine),
    .done        (done)
  );

  assign phase_coarse = (phase == PH_COARSE);

  for (genvar c = 0; c < N_COLS; c++) begin : g_col
    ts_column #(.P(P), .FB(FB)) u_col (
      .clk         (clk),
      .rst_n       (rst_n),
      .clr         (clr),
      .phase       (phase),
      .coarse_cnt  (coarse_cnt),
      .fine_cnt    (fine_cnt),
      .last_coarse (last_coarse),
      .last_fine   (last_fine),
      .comp        (comp[c]),
      .ref_en      (ref_en[c*K +: K]),
      .c_code      (coarse_code[c*P +: P]),
      .f_code      (fine_code[c*FB +: FB]),
      .sat_c       (sat_coarse[c]),
      .sat_f       (sat_fine[c])
    );
  end
endmodule

// File: tb/tb_ts_ss_sequencer.sv
`timescale 1ns/1ps
module tb_ts_ss_sequencer;
  localparam int P  = 3;
  localparam int FB = 10;
  localparam int NC = 4;
  localparam int K  = 1 << P;
  localparam int Q  = 1 << (FB - 1);
  localparam int CONV = K + (1 << FB);

  logic clk = 0, rst_n = 0, start = 0;
  logic [NC-1:0] comp;
  logic phase_coarse, done;
  logic [FB-1:0] ramp_code;
  logic [NC*K-1:0] ref_en;
  logic [NC*P-1:0] coarse_code;
  logic [NC*FB-1:0] fine_code;
  logic [NC-1:0] sat_coarse, sat_fine;

  int sig [NC];
  logic [NC-1:0] kill_c = '0, kill_f = '0;
  int vectors = 0, miscompares = 0;
  int cycles = 0;

  typedef struct { int col; int lvl; int c; int f; bit sc; bit sf; } exp_t;
  exp_t sb[$];

  ts_ss_sequencer #(.P(P), .FB(FB), .N_COLS(NC)) dut (
    .clk(clk), .rst_n(rst_n), .start(start), .comp(comp),
    .phase_coarse(phase_coarse), .ramp_code(ramp_code), .ref_en(ref_en),
    .coarse_code(coarse_code), .fine_code(fine_code),
    .sat_coarse(sat_coarse), .sat_fine(sat_fine), .done(done));

  always #2.5 clk = ~clk;

  function automatic int ref_idx(int c);
    for (int g = 0; g < K; g++) if (ref_en[c*K+g]) return g;
    return -1;
  endfunction

  // comparator + ladder + ramp model
  always_comb begin
    for (int c = 0; c < NC; c++) begin
      int k;
      k = ref_idx(c);
      if (k < 0) comp[c] = 1'b0;
      else if (phase_coarse) comp[c] = !kill_c[c] && ((K - k) * Q > sig[c]);
      else comp[c] = !kill_f[c] && (((K - 2 - k) * Q + int'(ramp_code)) >= sig[c]);
    end
  end

  task automatic check(bit ok, string tag, int act, int expv);
    vectors++;
    if (!ok) begin
      miscompares++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, expv, $time);
    end
  endtask

  function automatic exp_t predict(int c);
    exp_t e;
    e.col = c; e.lvl = sig[c]; e.sc = 1; e.c = 0; e.sf = 1; e.f = (1 << FB) - 1;
    if (!kill_c[c])
      for (int k = K - 1; k >= 0; k--)
        if ((K - k) * Q > sig[c]) begin e.c = k; e.sc = 0; break; end
    if (!kill_f[c])
      for (int f = 0; f < (1 << FB); f++)
        if ((K - 2 - e.c) * Q + f >= sig[c]) begin e.f = f; e.sf = 0; break; end
    return e;
  endfunction

  // monitor: pop expectations when the strobe appears
  always @(negedge clk) begin
    if (rst_n && done) begin
      for (int i = 0; i < NC; i++) begin
        exp_t e;
        int ac, af;
        if (sb.size() == 0) begin
          check(0, "R8 unexpected done", 1, 0);
          break;
        end
        e = sb.pop_front();
        ac = int'(coarse_code[e.col*P +: P]);
        af = int'(fine_code[e.col*FB +: FB]);
        check(ac == e.c, e.sc ? "R6 R10 coarse code" : "R3 R10 coarse code", ac, e.c);
        check(af == e.f, e.sf ? "R7 R10 fine code" : "R5 R10 fine code", af, e.f);
        check(sat_coarse[e.col] == e.sc, "R6 sat_coarse", sat_coarse[e.col], e.sc);
        check(sat_fine[e.col] == e.sf, "R7 sat_fine", sat_fine[e.col], e.sf);
        if (!e.sc && !e.sf)
          check(af + (K - 2 - ac) * Q == e.lvl, "R11 reconstruct", af + (K - 2 - ac) * Q, e.lvl);
      end
    end
  end

  task automatic convert(int s0, int s1, int s2, int s3, bit busy_start);
    int n;
    exp_t e0;
    sig[0] = s0; sig[1] = s1; sig[2] = s2; sig[3] = s3;
    for (int c = 0; c < NC; c++) sb.push_back(predict(c));
    e0 = predict(0);
    @(negedge clk); start = 1;
    @(negedge clk); start = 0;
    n = 1;
    while (!done && n <= CONV + 5) begin
      if (n <= K) begin
        check(phase_coarse == 1 && ref_idx(0) == K - n, "R2 coarse switch", ref_idx(0), K - n);
        if (n == 1) check(&ramp_code, "R2 ramp full scale", ramp_code, (1 << FB) - 1);
      end else if (n <= CONV) begin
        check(phase_coarse == 0 && int'(ramp_code) == n - K - 1, "R4 ramp count", ramp_code, n - K - 1);
        if (n == K + 2) check(ref_idx(0) == e0.c, "R4 fine switch", ref_idx(0), e0.c);
      end
      if (busy_start && n == 300) start = 1;
      @(negedge clk);
      start = 0;
      n++;
    end
    check(n == CONV + 1, "R8 done timing", n, CONV + 1);
    check(ref_en == '0 && !phase_coarse, "R8 idle at done", ref_en, 0);
    @(negedge clk);
    check(done == 0, "R8 single cycle", done, 0);
    repeat (3) @(negedge clk);
    check(ref_en == '0 && done == 0, "R9 no second conversion", ref_en, 0);
  endtask

  initial begin
    for (int c = 0; c < NC; c++) sig[c] = 0;
    repeat (3) @(negedge clk);
    check(done == 0 && phase_coarse == 0 && ref_en == '0 && ramp_code == '0, "R1 reset ctrl", ref_en, 0);
    check(coarse_code == '0 && fine_code == '0 && sat_coarse == '0 && sat_fine == '0, "R1 reset codes", fine_code, 0);
    rst_n = 1;
    @(negedge clk);
    convert(0, 511, 512, 4095, 0);
    convert(3071, 3072, 1000, 2047, 0);
    convert(2048, 100, 3500, 1536, 1);
    kill_c = 4'b0010;
    convert(700, 700, 700, 700, 0);
    kill_c = 4'b0000; kill_f = 4'b0100;
    convert(1234, 2222, 3333, 44, 0);
    kill_c = 4'b1000; kill_f = 4'b1001;
    convert(3800, 5, 2600, 3100, 0);
    kill_c = '0; kill_f = '0;
    convert(255, 1023, 1024, 4000, 0);
    check(sb.size() == 0, "R8 all results seen", sb.size(), 0);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      miscompares++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end
endmodule